// File: doc/BRIEF.md
# Programmable Event Probe Unit

The block gives a companion core a low-cost view of a main processor's activity. It holds several independent probes. Each probe owns a counter that advances on a per-probe increment strobe, plus a comparator and two trigger registers. A probe raises an event when its counter newly satisfies the configured condition. That condition is one of four: equal to the low trigger, inside the inclusive low..high window, outside that window, or never.

Each event is a word that carries a source number and a snapshot of the counter. Probe events and events that software writes directly all enter one shared queue. The companion core takes items from the queue head with a pop strobe, so it never has to poll the counters. When several sources want the queue in the same cycle, a fixed priority decides the order. When the queue is full, the event is dropped and a sticky overflow flag is set.

A single register port handles all programming and status. Writes are synchronous. Reads are combinational from a separate read address. Each probe owns four words at address `4*i`:
- +0 is control: bit0 enable, bits[2:1] mode.
- +1 is the low trigger.
- +2 is the high trigger.
- +3 is the counter.

Two global words follow the probe words. Address `4*NPROBE` is the software event word. Address `4*NPROBE+1` is the status word.

Top module: `event_probe_unit`

## Requirements
- R1: An enabled probe's counter advances by exactly one on each clock edge where its increment strobe is high. A write to the probe's counter word (offset +3) loads the written value, and that write wins over an increment in the same cycle.
- R2: In mode 0 (control bits[2:1]=0), a probe fires when its counter equals its low trigger (offset +1). Mode 3 never fires.
- R3: In mode 1, a probe fires when low <= counter <= high, with both bounds inclusive. The high trigger is at offset +2.
- R4: In mode 2, a probe fires when counter < low or counter > high.
- R5: A probe produces one event only on the cycle its condition changes from false to true. It produces nothing more while the condition stays true. A counter write that makes the condition true also counts as such a change.
- R6: A probe whose enable bit (control bit0) is clear never produces events and ignores its increment strobe. Because the condition history is cleared while disabled, enabling a probe whose condition already holds produces exactly one event.
- R7: A write to address 4*NPROBE pushes a software event. Its source number is NPROBE and its value is the written data. It is visible at the queue head in the cycle after the write edge.
- R8: A probe event carries source number = probe index and value = the counter value in the cycle the condition became true. It reaches the queue head two clock edges after the increment edge that caused it, when the queue is otherwise empty.
- R9: At most one event enters the queue per cycle. Software goes first, then lower probe index. A probe that loses arbitration keeps its event pending and is served in a later cycle, in priority order.
- R10: An event granted while the queue is full is discarded and sets the sticky overflow flag (status bit0). Writing 1 to status bit0 clears the flag.
- R11: The queue returns events in arrival order. `ev_valid` is high exactly while the queue is not empty, and `ev_pop` removes the head. The status word holds bit1 = empty, bit2 = full, and the occupancy in bits starting at bit3.
- R12: After reset, all control, trigger and counter words read zero, the queue is empty, and overflow is clear, so the status word reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | NPROBE | Per-probe counter increment strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | AW | Register write address |
| reg_wdata_i | input | VW | Register write data |
| reg_raddr_i | input | AW | Register read address |
| reg_rdata_o | output | VW | Combinational read data |
| ev_valid_o | output | 1 | Queue head holds an event |
| ev_pop_i | input | 1 | Remove the queue head |
| ev_src_o | output | SRCW | Source number of the head event |
| ev_value_o | output | VW | Value snapshot of the head event |

## Verification
A software event is due at the queue head in the cycle after its write edge. A probe event is due two edges after the increment edge. The extra edge comes from the registered counter, after which the comparison is made and the queue is written. A probe that loses arbitration adds one edge per higher-priority winner.

The bench drives every input at the falling edge and samples there. With the consumer paused, it checks that `ev_valid` is still low one falling edge after an increment and high on the next. Elsewhere a scoreboard queue of expected events is filled by the driver tasks. A monitor pops and compares each head in order, and any event that arrives with nothing expected counts as a failure.

// File: rtl/evp_pkg.sv
package evp_pkg;

    typedef enum logic [1:0] {
        MODE_EQ  = 2'd0,
        MODE_IN  = 2'd1,
        MODE_OUT = 2'd2,
        MODE_OFF = 2'd3
    } probe_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_CNT  = 2'd3
    } probe_sel_e;

endpackage

// File: rtl/evp_probe.sv
module evp_probe
    import evp_pkg::*;
#(
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          wr_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [VW-1:0] wr_data_i,
    input  logic          grant_i,
    output logic          en_o,
    output logic [1:0]    mode_o,
    output logic [VW-1:0] lo_o,
    output logic [VW-1:0] hi_o,
    output logic [VW-1:0] cnt_o,
    output logic          req_o,
    output logic [VW-1:0] snap_o,
    output logic          lost_o
);

    typedef struct packed {
        logic          en;
        probe_mode_e   mode;
        logic [VW-1:0] lo;
        logic [VW-1:0] hi;
        logic [VW-1:0] cnt;
        logic          prev;
        logic          pend;
        logic [VW-1:0] snap;
    } probe_st_t;

    probe_st_t st_q, st_d;
    logic      cond;
    logic      fire;
    logic      lost;

    always_comb begin
        st_d = st_q;
        lost = 1'b0;
        case (st_q.mode)
            MODE_EQ:  cond = (st_q.cnt == st_q.lo);
            MODE_IN:  cond = (st_q.cnt >= st_q.lo) && (st_q.cnt <= st_q.hi);
            MODE_OUT: cond = (st_q.cnt < st_q.lo) || (st_q.cnt > st_q.hi);
            default:  cond = 1'b0;
        endcase
        fire      = st_q.en && cond && !st_q.prev;
        st_d.prev = st_q.en && cond;

        // a grant always serves the oldest request (pending before fresh)
        if (grant_i) begin
            if (st_q.pend && fire) begin
                st_d.pend = 1'b1;
                st_d.snap = st_q.cnt;
            end else begin
                st_d.pend = 1'b0;
            end
        end else if (fire) begin
            if (st_q.pend) begin
                lost = 1'b1;
            end else begin
                st_d.pend = 1'b1;
                st_d.snap = st_q.cnt;
            end
        end

        if (st_q.en && inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (wr_i) begin
            case (probe_sel_e'(wr_sel_i))
                SEL_CTRL: begin
                    st_d.en   = wr_data_i[0];
                    st_d.mode = probe_mode_e'(wr_data_i[2:1]);
                end
                SEL_LO:  st_d.lo  = wr_data_i;
                SEL_HI:  st_d.hi  = wr_data_i;
                default: st_d.cnt = wr_data_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign mode_o = st_q.mode;
    assign lo_o   = st_q.lo;
    assign hi_o   = st_q.hi;
    assign cnt_o  = st_q.cnt;
    assign req_o  = st_q.pend || fire;
    assign snap_o = st_q.pend ? st_q.snap : st_q.cnt;
    assign lost_o = lost;

    // R5: a fresh trigger can never repeat on the following cycle
    assert_single_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R6: a disabled probe without a counter write keeps its count
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !(wr_i && wr_sel_i == 2'd3)) |=> $stable(cnt_o));

    // R9: an ungranted pending event waits for a later slot
    assert_pending_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !grant_i) |=> st_q.pend);

endmodule

// File: rtl/evp_arb.sv
module evp_arb #(
    parameter int N = 2
) (
    input  logic         sw_req_i,
    input  logic [N-1:0] req_i,
    output logic         sw_gnt_o,
    output logic [N-1:0] gnt_o
);

    logic taken;

    always_comb begin
        sw_gnt_o = sw_req_i;
        gnt_o    = '0;
        taken    = sw_req_i;
        for (int k = 0; k < N; k++) begin
            if (req_i[k] && !taken) begin
                gnt_o[k] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/evp_fifo.sv
module evp_fifo #(
    parameter int EW    = 18,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [EW-1:0] data_i,
    input  logic          pop_i,
    output logic [EW-1:0] data_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     do_push;
    logic     do_pop;

    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign data_o  = st_q.mem[st_q.rp];
    assign cnt_o   = st_q.cnt;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.mem[st_q.wp] = data_i;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: occupancy never exceeds the storage
    assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CW'(DEPTH));

    // R11: a lone pop removes exactly one entry
    assert_fifo_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !push_i) |=> (cnt_o == $past(cnt_o) - 1'b1));

endmodule

// File: rtl/event_probe_unit.sv
module event_probe_unit
    import evp_pkg::*;
#(
    parameter int  NPROBE = 2,
    parameter int  VW     = 16,
    parameter int  DEPTH  = 8,
    localparam int AW     = $clog2(4 * NPROBE + 2),
    localparam int SRCW   = $clog2(NPROBE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPROBE-1:0] inc_i,
    input  logic              reg_wr_i,
    input  logic [AW-1:0]     reg_waddr_i,
    input  logic [VW-1:0]     reg_wdata_i,
    input  logic [AW-1:0]     reg_raddr_i,
    output logic [VW-1:0]     reg_rdata_o,
    output logic              ev_valid_o,
    input  logic              ev_pop_i,
    output logic [SRCW-1:0]   ev_src_o,
    output logic [VW-1:0]     ev_value_o
);

    localparam int EW     = SRCW + VW;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int SWEV_A = 4 * NPROBE;
    localparam int STAT_A = 4 * NPROBE + 1;

    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [NPROBE-1:0]         p_wr, p_en, p_req, p_gnt, p_lost;
    logic [NPROBE-1:0][1:0]    p_mode;
    logic [NPROBE-1:0][VW-1:0] p_lo, p_hi, p_cnt, p_snap;
    logic                      sw_req, sw_gnt, any_gnt, push, drop, clr;
    logic [EW-1:0]             push_data, head;
    logic                      q_empty, q_full;
    logic [CW-1:0]             q_cnt;

    for (genvar i = 0; i < NPROBE; i++) begin : g_probe
        assign p_wr[i] = reg_wr_i && (int'(reg_waddr_i) < SWEV_A)
                         && ((int'(reg_waddr_i) / 4) == i);
        evp_probe #(.VW(VW)) i_probe (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc_i[i]),
            .wr_i      (p_wr[i]),
            .wr_sel_i  (reg_waddr_i[1:0]),
            .wr_data_i (reg_wdata_i),
            .grant_i   (p_gnt[i]),
            .en_o      (p_en[i]),
            .mode_o    (p_mode[i]),
            .lo_o      (p_lo[i]),
            .hi_o      (p_hi[i]),
            .cnt_o     (p_cnt[i]),
            .req_o     (p_req[i]),
            .snap_o    (p_snap[i]),
            .lost_o    (p_lost[i])
        );
    end

    assign sw_req = reg_wr_i && (int'(reg_waddr_i) == SWEV_A);
    assign clr    = reg_wr_i && (int'(reg_waddr_i) == STAT_A) && reg_wdata_i[0];

    evp_arb #(.N(NPROBE)) i_arb (
        .sw_req_i (sw_req),
        .req_i    (p_req),
        .sw_gnt_o (sw_gnt),
        .gnt_o    (p_gnt)
    );

    always_comb begin
        push_data = {SRCW'(NPROBE), reg_wdata_i};
        for (int k = NPROBE - 1; k >= 0; k--) begin
            if (p_gnt[k]) begin
                push_data = {SRCW'(k), p_snap[k]};
            end
        end
        if (sw_gnt) begin
            push_data = {SRCW'(NPROBE), reg_wdata_i};
        end
    end

    assign any_gnt = sw_gnt || (|p_gnt);
    assign push    = any_gnt && !q_full;
    assign drop    = any_gnt && q_full;

    evp_fifo #(.EW(EW), .DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (push_data),
        .pop_i   (ev_pop_i),
        .data_o  (head),
        .empty_o (q_empty),
        .full_o  (q_full),
        .cnt_o   (q_cnt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = (st_q.ovf && !clr) || drop || (|p_lost);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (int'(reg_raddr_i) == STAT_A) begin
            reg_rdata_o = VW'({q_cnt, q_full, q_empty, st_q.ovf});
        end else begin
            for (int k = 0; k < NPROBE; k++) begin
                if ((int'(reg_raddr_i) / 4) == k) begin
                    case (reg_raddr_i[1:0])
                        2'd0:    reg_rdata_o = VW'({p_mode[k], p_en[k]});
                        2'd1:    reg_rdata_o = p_lo[k];
                        2'd2:    reg_rdata_o = p_hi[k];
                        default: reg_rdata_o = p_cnt[k];
                    endcase
                end
            end
        end
    end

    assign ev_valid_o = !q_empty;
    assign ev_src_o   = head[EW-1:VW];
    assign ev_value_o = head[VW-1:0];

    // R9: one winner per cycle, and software is never refused
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_gnt, p_gnt}));
    assert_sw_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> (sw_gnt && p_gnt == '0));

    // R7: a software event with room appears at the head next cycle
    assert_sw_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !q_full) |=> ev_valid_o);

    // R10: overflow is sticky until cleared, and a drop sets it
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr) |=> st_q.ovf);
    assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> st_q.ovf);

endmodule

// File: tb/test_event_probe_unit.sv
module test_event_probe_unit;

    localparam int NP     = 2;
    localparam int VW     = 16;
    localparam int DEPTH  = 8;
    localparam int AW     = 4;
    localparam int SRCW   = 2;
    localparam int SWEV_A = 8;
    localparam int STAT_A = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     inc = '0;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     waddr = '0;
    logic [VW-1:0]     wdata = '0;
    logic [AW-1:0]     raddr = '0;
    logic [VW-1:0]     rdata;
    logic              ev_valid;
    logic              ev_pop = 1'b0;
    logic [SRCW-1:0]   ev_src;
    logic [VW-1:0]     ev_value;

    int    checks = 0;
    int    errors = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R12";
    logic [SRCW+VW-1:0] exp_q[$];

    always #4 clk = ~clk;

    event_probe_unit #(.NPROBE(NP), .VW(VW), .DEPTH(DEPTH)) i_event_probe_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (inc),
        .reg_wr_i    (reg_wr),
        .reg_waddr_i (waddr),
        .reg_wdata_i (wdata),
        .reg_raddr_i (raddr),
        .reg_rdata_o (rdata),
        .ev_valid_o  (ev_valid),
        .ev_pop_i    (ev_pop),
        .ev_src_o    (ev_src),
        .ev_value_o  (ev_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1;
        waddr  = AW'(addr);
        wdata  = VW'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int addr, input int exp, input string req);
        raddr = AW'(addr);
        #1;
        check(req, 32'(rdata), 32'(exp));
    endtask

    task automatic pulse(input logic [NP-1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            inc = m;
            @(negedge clk);
            inc = '0;
        end
    endtask

    task automatic expect_ev(input int src, input int val);
        exp_q.push_back({SRCW'(src), VW'(val)});
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !ev_valid) break;
        end
        check(req, 32'(exp_q.size()), 32'd0);
    endtask

    // scoreboard monitor: compares and pops the head in order
    initial begin
        forever begin
            @(negedge clk);
            ev_pop = 1'b0;
            if (rst_n && mon_en && ev_valid) begin
                if (exp_q.size() == 0) begin
                    check(cur_req, {14'd0, ev_src, ev_value}, 32'hFFFF_FFFF);
                end else begin
                    check(cur_req, 32'({ev_src, ev_value}), 32'(exp_q.pop_front()));
                end
                ev_pop = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        cur_req = "R12";
        rd_chk(STAT_A, 2, "R12");
        rd_chk(0, 0, "R12");
        rd_chk(7, 0, "R12");
        check("R12", 32'(ev_valid), 0);
        mon_en = 1'b1;

        // R1: counting and counter load (mode 3 never fires)
        cur_req = "R1";
        wr(0, 7);
        pulse(2'b01, 5);
        rd_chk(3, 5, "R1");
        wr(3, 100);
        rd_chk(3, 100, "R1");

        // R2 / R8: equal mode, timing of a probe event
        cur_req = "R2";
        wr(1, 103);
        wr(0, 1);
        pulse(2'b01, 2);
        mon_en = 1'b0;
        @(negedge clk);
        inc = 2'b01;
        @(negedge clk);
        inc = '0;
        check("R8", 32'(ev_valid), 0);
        @(negedge clk);
        check("R8", 32'(ev_valid), 1);
        check("R8", 32'({ev_src, ev_value}), 32'({2'd0, 16'd103}));
        expect_ev(0, 103);
        mon_en = 1'b1;
        pulse(2'b01, 2);
        drain("R2");

        // R5: counter write re-entering the condition fires once
        cur_req = "R5";
        expect_ev(0, 103);
        wr(3, 103);
        repeat (4) @(negedge clk);
        drain("R5");

        // R3: inside window, inclusive bounds, one event on entry
        cur_req = "R3";
        wr(5, 10);
        wr(6, 12);
        wr(7, 0);
        wr(4, 3);
        expect_ev(1, 10);
        pulse(2'b10, 15);
        drain("R3");
        rd_chk(7, 15, "R3");

        // R4: outside window
        cur_req = "R4";
        wr(4, 0);
        wr(7, 11);
        wr(4, 5);
        pulse(2'b10, 1);
        expect_ev(1, 13);
        pulse(2'b10, 2);
        drain("R4");

        // R6: disabled probe is frozen and silent; enabling fires once
        cur_req = "R6";
        wr(4, 0);
        pulse(2'b10, 4);
        rd_chk(7, 14, "R6");
        wr(5, 14);
        repeat (4) @(negedge clk);
        check("R6", 32'(ev_valid), 0);
        expect_ev(1, 14);
        wr(4, 1);
        drain("R6");
        wr(4, 0);

        // R9: software plus two probes in the same cycle
        cur_req = "R9";
        wr(0, 0);
        wr(1, 200);
        wr(3, 199);
        wr(0, 1);
        wr(5, 50);
        wr(7, 49);
        wr(4, 1);
        expect_ev(2, 16'h5A5A);
        expect_ev(0, 200);
        expect_ev(1, 50);
        @(negedge clk);
        inc = 2'b11;
        @(negedge clk);
        inc = '0;
        reg_wr = 1'b1;
        waddr  = AW'(SWEV_A);
        wdata  = 16'h5A5A;
        @(negedge clk);
        reg_wr = 1'b0;
        drain("R9");

        // R7 / R10 / R11: fill the queue, overflow, clear, drain in order
        cur_req = "R10";
        mon_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            expect_ev(2, 16'h0100 + k);
            wr(SWEV_A, 16'h0100 + k);
            if (k == 0) begin
                check("R7", 32'(ev_valid), 1);
                check("R7", 32'({ev_src, ev_value}), 32'({2'd2, 16'h0100}));
            end
        end
        wr(SWEV_A, 16'hDEAD);
        rd_chk(STAT_A, 1 + 4 + (DEPTH << 3), "R10");
        wr(STAT_A, 1);
        rd_chk(STAT_A, 4 + (DEPTH << 3), "R10");
        cur_req = "R11";
        mon_en = 1'b1;
        drain("R11");
        rd_chk(STAT_A, 2, "R11");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule